// File: doc/BRIEF.md
# Channel Select and Tolerance Memory Controller

This block is the operator-facing half of a multi-channel monitor. It holds the channel number shown on the front panel. A pair of held push buttons steps that number up or down. Channel 0 is the real-time clock. Channels 1 to N are data inputs, and the three channels above N carry calibration references. The number wraps around at both ends of that range.

The block also keeps one compression tolerance per channel. A second pair of buttons steps the tolerance of the currently selected channel only. The legal settings are 1 to 15 percent plus a special value of 99, which means off. Every entry comes out of reset as off. A button acts once on press and then repeats at a fixed interval, counted in pulses of a slow tick input. A compression scanner reads any channel's tolerance through a separate read port. That port has priority over button writes: a write that collides with a read is held back and committed in the first cycle without a read.

Top module: `chan_tol_ctrl`

## Requirements
- R1: After reset, the selected channel is 0, every channel's tolerance reads 99, and the read-valid output is low.
- R2: Each channel step moves the selected channel by one. Stepping up from the highest channel (N+3) gives 0, and stepping down from 0 gives N+3.
- R3: A button press acts at the first clock edge on which the button is seen high. While the button stays high, one further step occurs on every TICKS_PER_STEP-th tick pulse. Releasing the button stops the stepping and restarts the count.
- R4: Tolerance up-steps go 1, 2, ... 15, then 99. An up-step at 99 leaves 99.
- R5: Tolerance down-steps go from 99 to 15 and then down by one. A down-step at 1 leaves 1.
- R6: A tolerance step changes only the entry of the selected channel. Every other channel's entry keeps its value.
- R7: A read request on rd_en_i with rd_chan_i returns that channel's stored tolerance on rd_tol_o, with rd_valid_o high, in the cycle after the request. A channel number above N+3 reads as 99.
- R8: A tolerance step taken while a read is active does not change the value the read returns. The display shows the new value at once. The memory entry takes the new value in the first cycle with rd_en_i low.
- R9: Up and down steps of the same pair that occur in the same cycle cancel, and the value is left unchanged.
- R10: Tolerances are coded as plain 7-bit binary numbers: 1 to 15, and 99 for off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse that paces the auto-repeat |
| chan_up_i | input | 1 | Channel up button, debounced, high while held |
| chan_dn_i | input | 1 | Channel down button, debounced, high while held |
| tol_up_i | input | 1 | Tolerance up button, debounced, high while held |
| tol_dn_i | input | 1 | Tolerance down button, debounced, high while held |
| sel_chan_o | output | CH_W | Selected channel number |
| sel_tol_o | output | 7 | Tolerance of the selected channel (1 to 15, or 99) |
| rd_en_i | input | 1 | Scanner read request |
| rd_chan_i | input | CH_W | Channel to read |
| rd_tol_o | output | 7 | Read data, registered |
| rd_valid_o | output | 1 | High in the cycle after a read request |

## Verification
The bench builds the block with five data channels and four ticks per repeat step. With nine channels, both wrap points are a few presses away. A channel number of 12 fits the 4-bit port while lying past the last channel, so the out-of-range read is reachable. Four ticks per step makes it practical to check the cycle-exact boundary between the third and the fourth tick of a held button, and the count restart after release. Both tolerance saturation ends and the 15 to 99 jump are walked in full.

// File: rtl/chan_tol_pkg.sv
package chan_tol_pkg;
  localparam int unsigned TOL_W     = 7;
  localparam int unsigned CODE_W    = 4;
  localparam logic [TOL_W-1:0] TOL_OFF = 7'd99;
  localparam logic [CODE_W-1:0] CODE_MAX = 4'd15;

  // stored code: 0 = off, 1..15 = percent
  typedef logic [CODE_W-1:0] tol_code_t;

  function automatic logic [TOL_W-1:0] code_to_disp(tol_code_t c);
    return (c == '0) ? TOL_OFF : {3'b000, c};
  endfunction

  function automatic tol_code_t code_step(tol_code_t c, logic up, logic dn);
    tol_code_t n;
    n = c;
    if (up && !dn) begin
      if (c == CODE_MAX) n = '0;
      else if (c != '0) n = c + 1'b1;
    end else if (dn && !up) begin
      if (c == '0) n = CODE_MAX;
      else if (c != 4'd1) n = c - 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/btn_repeat.sv
module btn_repeat #(
  parameter int unsigned TICKS_PER_STEP = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic held_i,
  output logic step_o
);
  localparam int unsigned CNT_W = $clog2(TICKS_PER_STEP + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_STEP - 1);

  logic             held_q;
  logic [CNT_W-1:0] cnt_q;
  logic             press;
  logic             rpt;

  assign press  = held_i && !held_q;
  assign rpt    = held_i && held_q && tick_i && (cnt_q == CNT_LAST);
  assign step_o = press || rpt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      held_q <= held_i;
      if (!held_i || press || rpt) cnt_q <= '0;
      else if (tick_i)             cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_step_needs_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> held_i);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/chan_sel.sv
module chan_sel #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            up_i,
  input  logic            dn_i,
  output logic [CH_W-1:0] chan_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= '0;
    else if (up_i && !dn_i) chan_q <= (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
    else if (dn_i && !up_i) chan_q <= (chan_q == '0) ? LAST_CH : chan_q - 1'b1;
  end

  assign chan_o = chan_q;

  assert_chan_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_q <= LAST_CH);
  assert_wrap_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !dn_i && chan_q == LAST_CH) |=> (chan_q == '0));
  assert_wrap_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && chan_q == '0) |=> (chan_q == LAST_CH));
  assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i) |=> $stable(chan_q));
endmodule

// File: rtl/tol_mem.sv
module tol_mem
  import chan_tol_pkg::*;
#(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  sel_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [TOL_W-1:0] sel_tol_o,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [TOL_W-1:0] rd_tol_o,
  output logic             rd_valid_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  tol_code_t       mem_q [NUM_CH];
  logic            pend_v_q;
  logic [CH_W-1:0] pend_addr_q;
  tol_code_t       pend_data_q;
  tol_code_t       cur_code;
  tol_code_t       rd_code;
  tol_code_t       rd_q;
  logic            rd_v_q;
  logic            do_step;
  logic            commit;

  // display and stepping see a pending write for the selected channel
  assign cur_code = (pend_v_q && pend_addr_q == sel_i) ? pend_data_q : mem_q[sel_i];
  assign do_step  = up_i ^ dn_i;
  assign commit   = pend_v_q && !rd_en_i;
  assign rd_code  = (rd_chan_i <= LAST_CH) ? mem_q[rd_chan_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
    end else if (commit) begin
      mem_q[pend_addr_q] <= pend_data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (do_step) begin
      pend_v_q    <= 1'b1;
      pend_addr_q <= sel_i;
      pend_data_q <= code_step(cur_code, up_i, dn_i);
    end else if (commit) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= rd_en_i;
      if (rd_en_i) rd_q <= rd_code;
    end
  end

  assign sel_tol_o  = code_to_disp(cur_code);
  assign rd_tol_o   = code_to_disp(rd_q);
  assign rd_valid_o = rd_v_q;

  assert_tol_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_tol_o >= 7'd1 && sel_tol_o <= 7'd15) || sel_tol_o == TOL_OFF));
  assert_rd_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_defer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v_q && rd_en_i) |=> pend_v_q);
  assert_no_write_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !do_step) |=> $stable(pend_data_q));
endmodule

// File: rtl/chan_tol_ctrl.sv
module chan_tol_ctrl
  import chan_tol_pkg::*;
#(
  parameter int unsigned NUM_DATA_CH    = 20,
  parameter int unsigned TICKS_PER_STEP = 500,
  parameter int unsigned CH_W           = $clog2(NUM_DATA_CH + 4)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             chan_up_i,
  input  logic             chan_dn_i,
  input  logic             tol_up_i,
  input  logic             tol_dn_i,
  output logic [CH_W-1:0]  sel_chan_o,
  output logic [TOL_W-1:0] sel_tol_o,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [TOL_W-1:0] rd_tol_o,
  output logic             rd_valid_o
);
  // clock channel + data channels + three references
  localparam int unsigned NUM_CH = NUM_DATA_CH + 4;
  localparam int unsigned NUM_BTN = 4;

  logic [NUM_BTN-1:0] btn_held;
  logic [NUM_BTN-1:0] btn_step;
  logic [CH_W-1:0]    chan;

  assign btn_held = {tol_dn_i, tol_up_i, chan_dn_i, chan_up_i};

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    btn_repeat #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_rpt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .held_i (btn_held[b]),
      .step_o (btn_step[b])
    );
  end

  chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (btn_step[0]),
    .dn_i   (btn_step[1]),
    .chan_o (chan)
  );

  tol_mem #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_tol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (chan),
    .up_i       (btn_step[2]),
    .dn_i       (btn_step[3]),
    .sel_tol_o  (sel_tol_o),
    .rd_en_i    (rd_en_i),
    .rd_chan_i  (rd_chan_i),
    .rd_tol_o   (rd_tol_o),
    .rd_valid_o (rd_valid_o)
  );

  assign sel_chan_o = chan;
endmodule

// File: tb/chan_tol_ctrl_tb_top.sv
module chan_tol_ctrl_tb_top;
  localparam int unsigned N   = 5;
  localparam int unsigned TPS = 4;
  localparam int unsigned CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cu = 1'b0, cd = 1'b0, tu = 1'b0, td = 1'b0;
  logic rd_en = 1'b0;
  logic [CW-1:0] rd_ch = '0;
  logic [CW-1:0] sel_chan;
  logic [6:0]    sel_tol, rd_tol;
  logic          rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chan_tol_ctrl #(.NUM_DATA_CH(N), .TICKS_PER_STEP(TPS), .CH_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .chan_up_i(cu), .chan_dn_i(cd), .tol_up_i(tu), .tol_dn_i(td),
    .sel_chan_o(sel_chan), .sel_tol_o(sel_tol),
    .rd_en_i(rd_en), .rd_chan_i(rd_ch), .rd_tol_o(rd_tol), .rd_valid_o(rd_valid)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // op: 0 chan up, 1 chan down, 2 tol up, 3 tol down
  task automatic press(int op);
    case (op)
      0: cu = 1'b1;
      1: cd = 1'b1;
      2: tu = 1'b1;
      default: td = 1'b1;
    endcase
    @(negedge clk);
    {cu, cd, tu, td} = 4'b0000;
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(logic [CW-1:0] ch);
    rd_en = 1'b1;
    rd_ch = ch;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // {op[1:0], exp chan[3:0], exp tol[6:0]}
  localparam logic [12:0] VEC [9] = '{
    {2'd2, 4'd0, 7'd99},  // R4 up at off stays off
    {2'd3, 4'd0, 7'd15},  // R5 off down -> 15
    {2'd2, 4'd0, 7'd99},  // R4 15 up -> off
    {2'd3, 4'd0, 7'd15},
    {2'd3, 4'd0, 7'd14},
    {2'd1, 4'd8, 7'd99},  // R2 wrap down, R6 other channel untouched
    {2'd0, 4'd0, 7'd14},  // R2 wrap up, R6 value kept
    {2'd0, 4'd1, 7'd99},  // R6
    {2'd1, 4'd0, 7'd14}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 chan", sel_chan, 0);
    chk("R1 tol", sel_tol, 99);
    chk("R1 valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(4'd6);
    chk("R1 rd tol", rd_tol, 99);

    foreach (VEC[i]) begin
      press(int'(VEC[i][12:11]));
      chk("R2/R4/R5/R6 chan", sel_chan, int'(VEC[i][10:7]));
      chk("R2/R4/R5/R6 tol", sel_tol, int'(VEC[i][6:0]));
    end

    // R5 saturate at 1
    for (int i = 0; i < 20; i++) press(3);
    chk("R5 floor", sel_tol, 1);
    // R4 climb to 15 then off
    for (int i = 0; i < 14; i++) press(2);
    chk("R4 top", sel_tol, 15);
    press(2);
    chk("R4 off", sel_tol, 99);
    press(3);
    chk("R5 back to 15", sel_tol, 15);

    // R7 reads
    do_read(4'd0);
    chk("R7 valid", rd_valid, 1);
    chk("R7 ch0", rd_tol, 15);
    do_read(4'd1);
    chk("R7 ch1", rd_tol, 99);
    do_read(4'd12);
    chk("R7 out of range", rd_tol, 99);
    @(negedge clk);
    chk("R7 valid drops", rd_valid, 0);

    // R8 step during active read
    rd_en = 1'b1; rd_ch = 4'd0; td = 1'b1;
    @(negedge clk);
    td = 1'b0;
    chk("R8 display new", sel_tol, 14);
    chk("R8 read old", rd_tol, 15);
    @(negedge clk);
    chk("R8 still old", rd_tol, 15);
    rd_en = 1'b0;
    @(negedge clk);
    do_read(4'd0);
    chk("R8 committed", rd_tol, 14);

    // R9 both buttons together
    cu = 1'b1; cd = 1'b1; tu = 1'b1; td = 1'b1;
    @(negedge clk);
    {cu, cd, tu, td} = 4'b0000;
    @(negedge clk);
    chk("R9 chan", sel_chan, 0);
    chk("R9 tol", sel_tol, 14);

    // R3 auto-repeat
    cu = 1'b1;
    @(negedge clk);
    chk("R3 immediate", sel_chan, 1);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    chk("R3 before interval", sel_chan, 1);
    pulse_tick();
    chk("R3 repeat", sel_chan, 2);
    for (int i = 0; i < TPS; i++) pulse_tick();
    chk("R3 second repeat", sel_chan, 3);
    pulse_tick();
    cu = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2 * TPS; i++) pulse_tick();
    chk("R3 released", sel_chan, 3);
    cu = 1'b1;
    @(negedge clk);
    chk("R3 repress", sel_chan, 4);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    chk("R3 count restarted", sel_chan, 4);
    cu = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule